// File: doc/BRIEF.md
# Multiprocessor-Format UART Receiver

This block receives asynchronous serial frames in which, when the multiprocessor format is chosen, one extra bit after the data marks the frame as an ID frame (bit at 1) or as a data frame (bit at 0). Software can arm a filter so that the receiver skips data frames addressed to other stations without any trace. The first ID frame that arrives disarms the filter in hardware, so software can inspect the ID and decide whether to listen to the data that follows. To skip the next message, software re-arms the filter.

A simple register bus gives access to a control register, a status register and the received-data register. Two level interrupt outputs are provided: one for received data and one for receive errors. Bit timing comes from an external oversampling tick at 16 times the bit rate. The block takes one frame at a time and has no receive queue. When the data register is still full, a new frame is lost and reported as an overrun. The receiver cannot stall the line, so there is no back-pressure on the serial side.

Top module: `mpr_uart_rx`

## Requirements
- R1: After reset every register reads 0 and both interrupts are low. Address 0 is CTRL: bit0 receiver enable, bit1 interrupt enable, bit2 multiprocessor format, bit3 filter enable. Address 1 is STAT: bit0 data full, bit1 framing error, bit2 overrun, bit3 multiprocessor bit. Address 2 is the received data. Address 3 reads 0.
- R2: With the multiprocessor format off, a frame is one low start bit, 8 data bits sent LSB first and one stop bit. A frame loads the data register and sets the full flag.
- R3: A start is accepted only if the line is still low at the middle of the start bit. A shorter low pulse leaves every status flag and the data register unchanged.
- R4: A stop bit sampled low sets the framing-error flag. The data is still stored.
- R5: A frame that ends while the full flag is set sets the overrun flag and is discarded. The data register keeps its old value.
- R6: A status flag clears only when software writes 0 to it after reading it as 1. Writing 0 without that read, or writing 1, leaves the flag set.
- R7: With the multiprocessor format on and the filter armed, a frame whose multiprocessor bit is 0 is dropped. Neither data, full, framing-error nor overrun changes, even if its stop bit is low, and the filter stays armed.
- R8: A frame whose multiprocessor bit is 1 is accepted. It sets STAT bit3 and clears CTRL bit3 in hardware.
- R9: With the multiprocessor format off, the filter enable has no effect. Frames are accepted and the bit stays 1.
- R10: The receive interrupt is high while full is set and the interrupt enable is 1. The error interrupt is high while framing error or overrun is set and the interrupt enable is 1.
- R11: With the multiprocessor format on, STAT bit3 follows the multiprocessor bit of each accepted frame, including data frames taken after the filter is disarmed.
- R12: While the receiver enable is 0, traffic on the line changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| rxd | input | 1 | Serial line, idle high |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (arms flag clearing) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| rxi | output | 1 | Receive-data interrupt |
| eri | output | 1 | Receive-error interrupt |

## Verification
The bench sends data frames with a low stop bit while the filter is armed. A design that still ran error checks on dropped frames would raise the framing-error flag and the error interrupt. It then sends an ID frame and reads the control register. A design that left the filter armed would drop the data that follows. It tries to clear flags by writing 0 without a prior read, which a design with plain write-0-clear would obey. It also checks that an overrun leaves the old byte in place and that a short low glitch is rejected at the start-bit midpoint.

// File: rtl/mpr_pkg.sv
package mpr_pkg;
  typedef enum logic [1:0] {
    S_WAIT_HI = 2'd0,
    S_IDLE    = 2'd1,
    S_START   = 2'd2,
    S_BITS    = 2'd3
  } rx_state_e;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;

  localparam int C_RXEN = 0;
  localparam int C_IEN  = 1;
  localparam int C_MPF  = 2;
  localparam int C_FILT = 3;

  localparam int F_FULL = 0;
  localparam int F_FERR = 1;
  localparam int F_OVR  = 2;
  localparam int F_MPB  = 3;
endpackage

// File: rtl/mpr_sync.sv
module mpr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '1;
        else        chain <= d_i;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/mpr_rx_frame.sv
module mpr_rx_frame
  import mpr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable_i,
  input  logic              tick_i,
  input  logic              line_i,
  input  logic              mp_fmt_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              mpbit_o,
  output logic              stop_ok_o
);
  localparam int CNT_W = $clog2(OSR);
  localparam int BIT_W = $clog2(DATA_W + 3);
  localparam logic [CNT_W-1:0] MID    = CNT_W'(OSR/2 - 1);
  localparam logic [CNT_W-1:0] LAST_T = CNT_W'(OSR - 1);

  rx_state_e        st;
  logic [CNT_W-1:0] cnt;
  logic [BIT_W-1:0] bn;
  logic [DATA_W:0]  sr;
  logic             mode_q;
  logic [BIT_W-1:0] stop_idx;

  assign stop_idx = BIT_W'(DATA_W) + BIT_W'(mode_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_WAIT_HI;
      cnt       <= '0;
      bn        <= '0;
      sr        <= '0;
      mode_q    <= 1'b0;
      done_o    <= 1'b0;
      data_o    <= '0;
      mpbit_o   <= 1'b0;
      stop_ok_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!enable_i) begin
        st <= S_WAIT_HI;
      end else if (tick_i) begin
        unique case (st)
          S_WAIT_HI: if (line_i) st <= S_IDLE;
          S_IDLE: if (!line_i) begin
            st     <= S_START;
            cnt    <= '0;
            mode_q <= mp_fmt_i;
          end
          S_START: begin
            if (cnt == MID) begin
              cnt <= '0;
              bn  <= '0;
              st  <= line_i ? S_WAIT_HI : S_BITS;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_BITS: begin
            if (cnt == LAST_T) begin
              cnt <= '0;
              if (bn == stop_idx) begin
                done_o    <= 1'b1;
                stop_ok_o <= line_i;
                data_o    <= mode_q ? sr[DATA_W-1:0] : sr[DATA_W:1];
                mpbit_o   <= mode_q & sr[DATA_W];
                st        <= S_WAIT_HI;
              end else begin
                sr <= {line_i, sr[DATA_W:1]};
                bn <= bn + 1'b1;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: st <= S_WAIT_HI;
        endcase
      end
    end
  end

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R2
  bit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BITS) |-> (bn <= BIT_W'(DATA_W + 1)));
endmodule

// File: rtl/mpr_rx_regs.sv
module mpr_rx_regs
  import mpr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int REG_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [1:0]        addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic              done_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              mpbit_i,
  input  logic              stop_ok_i,
  output logic              rx_en_o,
  output logic              mp_fmt_o,
  output logic              rxi_o,
  output logic              eri_o
);
  logic rx_en_q, ien_q, mpf_q, filt_q;
  logic full_q, ferr_q, ovr_q, mpb_q;
  logic [2:0] seen_q;
  logic [DATA_W-1:0] data_q;
  logic filtering, drop, wr_ctrl, wr_stat, rd_stat;
  logic [2:0] flags;
  logic unused_wbits;

  assign filtering = mpf_q & filt_q;
  assign drop      = done_i & filtering & ~mpbit_i;
  assign wr_ctrl   = wr_i & (addr_i == A_CTRL);
  assign wr_stat   = wr_i & (addr_i == A_STAT);
  assign rd_stat   = rd_i & (addr_i == A_STAT);
  assign flags     = {ovr_q, ferr_q, full_q};
  assign unused_wbits = ^wdata_i[REG_W-1:4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_en_q <= 1'b0; ien_q <= 1'b0; mpf_q <= 1'b0; filt_q <= 1'b0;
      full_q  <= 1'b0; ferr_q <= 1'b0; ovr_q <= 1'b0; mpb_q <= 1'b0;
      seen_q  <= '0;
      data_q  <= '0;
    end else begin
      if (wr_ctrl) begin
        rx_en_q <= wdata_i[C_RXEN];
        ien_q   <= wdata_i[C_IEN];
        mpf_q   <= wdata_i[C_MPF];
        filt_q  <= wdata_i[C_FILT];
      end
      if (rd_stat) seen_q <= flags;
      if (wr_stat) begin
        if (!wdata_i[F_FULL] && seen_q[F_FULL]) begin full_q <= 1'b0; seen_q[F_FULL] <= 1'b0; end
        if (!wdata_i[F_FERR] && seen_q[F_FERR]) begin ferr_q <= 1'b0; seen_q[F_FERR] <= 1'b0; end
        if (!wdata_i[F_OVR]  && seen_q[F_OVR])  begin ovr_q  <= 1'b0; seen_q[F_OVR]  <= 1'b0; end
      end
      if (done_i && !drop) begin
        if (mpf_q && mpbit_i) filt_q <= 1'b0;
        mpb_q <= mpbit_i;
        if (full_q) begin
          ovr_q <= 1'b1;
        end else begin
          data_q <= data_i;
          full_q <= 1'b1;
        end
        if (!stop_ok_i) ferr_q <= 1'b1;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CTRL: rdata_o[3:0] = {filt_q, mpf_q, ien_q, rx_en_q};
      A_STAT: rdata_o[3:0] = {mpb_q, ovr_q, ferr_q, full_q};
      A_DATA: rdata_o[DATA_W-1:0] = data_q;
      default: rdata_o = '0;
    endcase
  end

  assign rx_en_o  = rx_en_q;
  assign mp_fmt_o = mpf_q;
  assign rxi_o    = full_q & ien_q;
  assign eri_o    = (ferr_q | ovr_q) & ien_q;

  // R7
  drop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drop && !wr_stat) |=> ($stable(flags) && $stable(data_q)));

  // R8
  id_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && mpf_q && filt_q && mpbit_i && !wr_ctrl) |=> !filt_q);

  // R5
  ovr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && !drop && full_q) |=> ($stable(data_q) && ovr_q));

  // R2
  accept_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && !drop && !full_q) |=> (full_q && data_q == $past(data_i)));

  // R6
  clear_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && !wdata_i[F_FULL] && !seen_q[F_FULL] && full_q) |=> full_q);
endmodule

// File: rtl/mpr_uart_rx.sv
module mpr_uart_rx #(
  parameter int DATA_W      = 8,
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       os_tick,
  input  logic       rxd,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       rxi,
  output logic       eri
);
  logic              line_s;
  logic              rx_en, mp_fmt;
  logic              f_done, f_mpbit, f_stop_ok;
  logic [DATA_W-1:0] f_data;

  mpr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(rxd), .q_o(line_s)
  );

  mpr_rx_frame #(.DATA_W(DATA_W), .OSR(OSR)) u_frame (
    .clk(clk), .rst_n(rst_n), .enable_i(rx_en), .tick_i(os_tick),
    .line_i(line_s), .mp_fmt_i(mp_fmt), .done_o(f_done),
    .data_o(f_data), .mpbit_o(f_mpbit), .stop_ok_o(f_stop_ok)
  );

  mpr_rx_regs #(.DATA_W(DATA_W), .REG_W(8)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_i(bus_wr), .rd_i(bus_rd),
    .addr_i(bus_addr), .wdata_i(bus_wdata), .rdata_o(bus_rdata),
    .done_i(f_done), .data_i(f_data), .mpbit_i(f_mpbit),
    .stop_ok_i(f_stop_ok), .rx_en_o(rx_en), .mp_fmt_o(mp_fmt),
    .rxi_o(rxi), .eri_o(eri)
  );
endmodule

// File: tb/sim_mpr_uart_rx.sv
module sim_mpr_uart_rx;
  logic clk = 1'b0, rst_n = 1'b0, os_tick = 1'b0, rxd = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic rxi, eri;
  int checks = 0, errors = 0;
  bit ended = 0;

  localparam int BITCLK = 64;

  always #2.5 clk = ~clk;

  mpr_uart_rx u0 (.*);

  initial begin : tick_gen
    int c = 0;
    forever begin
      @(negedge clk);
      os_tick = (c == 3);
      c = (c + 1) % 4;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1; #1 v = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic send(input logic [7:0] d, input logic use_mp, input logic mpb, input logic stop);
    @(negedge clk);
    rxd = 1'b0; repeat (BITCLK) @(negedge clk);
    for (int i = 0; i < 8; i++) begin rxd = d[i]; repeat (BITCLK) @(negedge clk); end
    if (use_mp) begin rxd = mpb; repeat (BITCLK) @(negedge clk); end
    rxd = stop; repeat (BITCLK) @(negedge clk);
    rxd = 1'b1; repeat (2*BITCLK) @(negedge clk);
  endtask

  task automatic clear_all();
    logic [7:0] v;
    rd(2'd1, v); wr(2'd1, 8'h00);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(2'd0, v); check("R1 ctrl", v, 0);
    rd(2'd1, v); check("R1 stat", v, 0);
    rd(2'd2, v); check("R1 data", v, 0);
    rd(2'd3, v); check("R1 addr3", v, 0);
    check("R1 rxi", rxi, 0); check("R1 eri", eri, 0);
  endtask

  task automatic t_plain();
    logic [7:0] v;
    wr(2'd0, 8'h03);
    send(8'hA5, 1'b0, 1'b0, 1'b1);
    rd(2'd2, v); check("R2 data", v, 8'hA5);
    check("R10 rxi", rxi, 1); check("R10 eri", eri, 0);
    wr(2'd1, 8'h00);
    rd(2'd1, v); check("R6 no clear without read", v[0], 1);
    wr(2'd1, 8'h01);
    rd(2'd1, v); check("R6 write 1 keeps", v[0], 1);
    rd(2'd1, v); wr(2'd1, 8'h00);
    rd(2'd1, v); check("R6 cleared", v, 0);
    check("R10 rxi low", rxi, 0);
  endtask

  task automatic t_ferr_ovr();
    logic [7:0] v;
    send(8'h5A, 1'b0, 1'b0, 1'b0);
    rd(2'd1, v); check("R4 stat", v, 8'h03);
    rd(2'd2, v); check("R4 data", v, 8'h5A);
    check("R10 eri", eri, 1);
    send(8'h11, 1'b0, 1'b0, 1'b1);
    rd(2'd1, v); check("R5 ovr", v[2], 1);
    rd(2'd2, v); check("R5 keep", v, 8'h5A);
    wr(2'd0, 8'h01);
    check("R10 masked rxi", rxi, 0); check("R10 masked eri", eri, 0);
    clear_all();
    rd(2'd1, v); check("R6 all clear", v, 0);
  endtask

  task automatic t_glitch();
    logic [7:0] v;
    @(negedge clk); rxd = 1'b0; repeat (8) @(negedge clk); rxd = 1'b1;
    repeat (3*BITCLK) @(negedge clk);
    rd(2'd1, v); check("R3 stat", v, 0);
    rd(2'd2, v); check("R3 data", v, 8'h5A);
  endtask

  task automatic t_filter();
    logic [7:0] v;
    wr(2'd0, 8'h0F);
    send(8'h77, 1'b1, 1'b0, 1'b1);
    send(8'h66, 1'b1, 1'b0, 1'b0);
    rd(2'd1, v); check("R7 stat", v, 0);
    rd(2'd2, v); check("R7 data", v, 8'h5A);
    rd(2'd0, v); check("R7 armed", v[3], 1);
    check("R7 eri", eri, 0);
    send(8'h3C, 1'b1, 1'b1, 1'b1);
    rd(2'd1, v); check("R8 stat", v, 8'h09);
    rd(2'd0, v); check("R8 disarm", v[3], 0);
    rd(2'd2, v); check("R8 data", v, 8'h3C);
    clear_all();
    send(8'hC3, 1'b1, 1'b0, 1'b1);
    rd(2'd1, v); check("R11 mpb 0", v, 8'h01);
    rd(2'd2, v); check("R11 data", v, 8'hC3);
    clear_all();
  endtask

  task automatic t_nofilter();
    logic [7:0] v;
    wr(2'd0, 8'h0B);
    send(8'h81, 1'b0, 1'b0, 1'b1);
    rd(2'd2, v); check("R9 data", v, 8'h81);
    rd(2'd0, v); check("R9 filt kept", v[3], 1);
    clear_all();
  endtask

  task automatic t_disabled();
    logic [7:0] v;
    wr(2'd0, 8'h02);
    send(8'hFF, 1'b0, 1'b0, 1'b1);
    rd(2'd1, v); check("R12 stat", v, 0);
    rd(2'd2, v); check("R12 data", v, 8'h81);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_plain();
    t_ferr_ovr();
    t_glitch();
    t_filter();
    t_nofilter();
    t_disabled();
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end
endmodule